// File: doc/BRIEF.md
# Page Protection Key Checker

This unit makes the final permission decision for one memory access once a page-table walk has gathered the page's attributes. It takes the combined user, writable and no-execute bits of the walk, the protection key of the leaf entry, the kind of access, the privilege of the access, and the paging control bits. From these it derives the read, write and execute rights the page grants.

Separately, it looks up the key in one of two 32-bit key-rights registers: one register serves pages marked user and the other serves supervisor pages. Each key can withdraw access or withdraw write permission. The two sets of rights are merged. The unit reports whether the access faults and whether the key rights caused the fault.

Each input beat is presented with a valid strobe. The result appears on registered outputs one clock later, so the unit can sit directly behind a walker stage.

Top module: `pkey_perm_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and carries that beat's result. Without `in_valid`, `out_valid` is low and `rights`, `fault` and `pk_err` keep their last values. Reset clears all four outputs to zero.
- R2: A user-mode access (`mode_user`=1) to a page whose user bit is clear gives `fault`=1, `rights`=000 and `pk_err`=0, whatever the key rights are.
- R3: Page write permission is granted when `pg_rw` is set, or when the access is supervisor-mode and `ctl_wp` is clear.
- R4: Page execute permission needs `pg_nx` clear. For a supervisor-mode access it is also withheld when `ctl_smep` is set and the page is a user page.
- R5: An implicit supervisor access (`implicit_sup`=1 with `mode_user`=0) to a user page gets neither read nor write permission. `implicit_sup` has no effect when `mode_user`=1.
- R6: The key register is chosen as follows. With `ctl_lma`=0 no key register applies. A user page uses `usr_key_rights` when `ctl_pke`=1. A supervisor page uses `sup_key_rights` when `ctl_pks`=1. In every other case the key rights permit everything.
- R7: Key k (0..15, on `leaf_key`) owns bits 2k and 2k+1 of the chosen register. Bit 2k is access-disable and bit 2k+1 is write-disable.
- R8: Access-disable removes read and write permission but never execute permission.
- R9: Write-disable removes write permission only when `mode_user`=1 or `ctl_wp`=1.
- R10: `rights` bit 0 is read, bit 1 is write and bit 2 is execute; it is the page rights ANDed with the key rights. `acc_type` 0 is read, 1 is write, 2 is fetch, and 3 is treated as fetch. `fault` is set when the rights bit for the access type is clear.
- R11: `pk_err` is set, together with `fault`, when the key rights alone deny the access type. This holds even when the page rights also deny it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| pg_user | input | 1 | Accumulated user bit of the walk |
| pg_rw | input | 1 | Accumulated writable bit |
| pg_nx | input | 1 | Accumulated no-execute bit |
| leaf_key | input | 4 | Protection key of the leaf entry |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 fetch |
| mode_user | input | 1 | Access made from user mode |
| implicit_sup | input | 1 | Implicit supervisor access |
| ctl_lma | input | 1 | Long mode active |
| ctl_wp | input | 1 | Supervisor write protection enable |
| ctl_smep | input | 1 | Supervisor fetch from user pages blocked |
| ctl_pke | input | 1 | Keys enabled for user pages |
| ctl_pks | input | 1 | Keys enabled for supervisor pages |
| usr_key_rights | input | 32 | Key-rights register for user pages |
| sup_key_rights | input | 32 | Key-rights register for supervisor pages |
| out_valid | output | 1 | Result valid |
| rights | output | 3 | Granted rights {exec, write, read} |
| fault | output | 1 | Access denied |
| pk_err | output | 1 | Denial caused by key rights |

## Verification
A page denial and a key denial can occur on the same beat. The clearest case is a write to a read-only page whose key also has access-disable set. Both `fault` and `pk_err` must then be set. The bench drives that case directly. It also drives the reverse case, where a user-mode access to a supervisor page meets an access-disabled key: here the early page violation must win and `pk_err` must stay clear. The full sweep crosses every key with every control and attribute pattern, so these overlaps also recur there, and each result is compared with an independent model.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_ALT   = 2'd3
   } acc_e;

   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } rights_t;
endpackage

// File: rtl/pkey_page_rights.sv
module pkey_page_rights
   import pkey_pkg::*;
(
   input  logic    pg_user,
   input  logic    pg_rw,
   input  logic    pg_nx,
   input  logic    mode_user,
   input  logic    implicit_sup,
   input  logic    ctl_wp,
   input  logic    ctl_smep,
   output rights_t page_r,
   output logic    user_viol
);
   logic imp_block;

   always_comb begin
      user_viol = mode_user & ~pg_user;
      imp_block = implicit_sup & ~mode_user & pg_user;
      page_r.r  = ~imp_block;
      page_r.w  = ~imp_block & (pg_rw | (~mode_user & ~ctl_wp));
      page_r.x  = ~pg_nx & (mode_user | ~(ctl_smep & pg_user));
   end
endmodule

// File: rtl/pkey_key_rights.sv
module pkey_key_rights
   import pkey_pkg::*;
#(
   parameter int NUM_KEYS   = 16,
   parameter int RIGHTS_W   = 32,
   parameter int KEY_W      = 4,
   parameter bit ONEHOT_MUX = 1'b0
) (
   input  logic [KEY_W-1:0]    key,
   input  logic                pg_user,
   input  logic                mode_user,
   input  logic                ctl_lma,
   input  logic                ctl_wp,
   input  logic                ctl_pke,
   input  logic                ctl_pks,
   input  logic [RIGHTS_W-1:0] usr_reg,
   input  logic [RIGHTS_W-1:0] sup_reg,
   output rights_t             key_r
);
   logic [RIGHTS_W-1:0] sel_reg;
   logic [NUM_KEYS-1:0] ad_vec;
   logic [NUM_KEYS-1:0] wd_vec;
   logic                ad_bit;
   logic                wd_bit;

   always_comb begin
      sel_reg = '0;
      if (ctl_lma) begin
         if (pg_user) sel_reg = ctl_pke ? usr_reg : '0;
         else         sel_reg = ctl_pks ? sup_reg : '0;
      end
   end

   for (genvar i = 0; i < NUM_KEYS; i++) begin : g_slot
      assign ad_vec[i] = sel_reg[2*i];
      assign wd_vec[i] = sel_reg[2*i+1];
   end

   if (ONEHOT_MUX) begin : g_onehot
      logic [NUM_KEYS-1:0] key_hot;
      for (genvar i = 0; i < NUM_KEYS; i++) begin : g_dec
         assign key_hot[i] = (key == KEY_W'(i));
      end
      assign ad_bit = |(key_hot & ad_vec);
      assign wd_bit = |(key_hot & wd_vec);
   end else begin : g_index
      assign ad_bit = ad_vec[key];
      assign wd_bit = wd_vec[key];
   end

   always_comb begin
      key_r.r = ~ad_bit;
      key_r.w = ~ad_bit & ~(wd_bit & (mode_user | ctl_wp));
      key_r.x = 1'b1;
   end
endmodule

// File: rtl/pkey_perm_unit.sv
module pkey_perm_unit
   import pkey_pkg::*;
#(
   parameter int NUM_KEYS   = 16,
   parameter int RIGHTS_W   = 32,
   parameter bit ONEHOT_MUX = 1'b0,
   localparam int KEY_W     = $clog2(NUM_KEYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                pg_user,
   input  logic                pg_rw,
   input  logic                pg_nx,
   input  logic [KEY_W-1:0]    leaf_key,
   input  logic [1:0]          acc_type,
   input  logic                mode_user,
   input  logic                implicit_sup,
   input  logic                ctl_lma,
   input  logic                ctl_wp,
   input  logic                ctl_smep,
   input  logic                ctl_pke,
   input  logic                ctl_pks,
   input  logic [RIGHTS_W-1:0] usr_key_rights,
   input  logic [RIGHTS_W-1:0] sup_key_rights,
   output logic                out_valid,
   output logic [2:0]          rights,
   output logic                fault,
   output logic                pk_err
);
   if (RIGHTS_W != 2 * NUM_KEYS) begin : g_bad_width
      $error("RIGHTS_W must hold two bits per key");
   end
   if (NUM_KEYS < 2 || (1 << KEY_W) != NUM_KEYS) begin : g_bad_keys
      $error("NUM_KEYS must be a power of two of at least 2");
   end

   rights_t page_r;
   rights_t key_r;
   rights_t final_r;
   logic    user_viol;
   logic    key_ok;
   logic    acc_ok;

   pkey_page_rights u_page (
      .pg_user      (pg_user),
      .pg_rw        (pg_rw),
      .pg_nx        (pg_nx),
      .mode_user    (mode_user),
      .implicit_sup (implicit_sup),
      .ctl_wp       (ctl_wp),
      .ctl_smep     (ctl_smep),
      .page_r       (page_r),
      .user_viol    (user_viol)
   );

   pkey_key_rights #(
      .NUM_KEYS   (NUM_KEYS),
      .RIGHTS_W   (RIGHTS_W),
      .KEY_W      (KEY_W),
      .ONEHOT_MUX (ONEHOT_MUX)
   ) u_key (
      .key       (leaf_key),
      .pg_user   (pg_user),
      .mode_user (mode_user),
      .ctl_lma   (ctl_lma),
      .ctl_wp    (ctl_wp),
      .ctl_pke   (ctl_pke),
      .ctl_pks   (ctl_pks),
      .usr_reg   (usr_key_rights),
      .sup_reg   (sup_key_rights),
      .key_r     (key_r)
   );

   always_comb begin
      final_r = user_viol ? rights_t'(3'b000) : (page_r & key_r);
      unique case (acc_e'(acc_type))
         ACC_READ:  begin acc_ok = final_r.r; key_ok = key_r.r; end
         ACC_WRITE: begin acc_ok = final_r.w; key_ok = key_r.w; end
         default:   begin acc_ok = final_r.x; key_ok = key_r.x; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         rights    <= 3'b000;
         fault     <= 1'b0;
         pk_err    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            rights <= final_r;
            fault  <= ~acc_ok;
            pk_err <= ~user_viol & ~key_ok;
         end
      end
   end

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(rights) && $stable(fault) && $stable(pk_err)));
   assert_user_viol_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_user && !pg_user) |=> (fault && rights == 3'b000 && !pk_err));
   assert_no_key_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ctl_lma) |=> !pk_err);
   assert_ad_keeps_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc_type[1]) |=> !pk_err);
   assert_fault_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (fault == !rights[($past(acc_type) == 2'd3) ? 2 : $past(acc_type)]));
   assert_pk_implies_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && pk_err) |-> fault);
endmodule

// File: tb/pkey_perm_unit_tb.sv
module pkey_perm_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        pg_user, pg_rw, pg_nx;
   logic [3:0]  leaf_key;
   logic [1:0]  acc_type;
   logic        mode_user, implicit_sup;
   logic        ctl_lma, ctl_wp, ctl_smep, ctl_pke, ctl_pks;
   logic [31:0] usr_key_rights, sup_key_rights;
   logic        out_valid;
   logic [2:0]  rights;
   logic        fault, pk_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pkey_perm_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .pg_user(pg_user), .pg_rw(pg_rw), .pg_nx(pg_nx),
      .leaf_key(leaf_key), .acc_type(acc_type),
      .mode_user(mode_user), .implicit_sup(implicit_sup),
      .ctl_lma(ctl_lma), .ctl_wp(ctl_wp), .ctl_smep(ctl_smep),
      .ctl_pke(ctl_pke), .ctl_pks(ctl_pks),
      .usr_key_rights(usr_key_rights), .sup_key_rights(sup_key_rights),
      .out_valid(out_valid), .rights(rights), .fault(fault), .pk_err(pk_err)
   );

   // Independent model from the requirements: returns {pk_err, fault, x, w, r}
   function automatic logic [4:0] model();
      logic r, w, x, kr, kw, ad, wd, need, have;
      logic [31:0] kreg;
      if (mode_user && !pg_user) return 5'b01000;              // R2
      r = !(!mode_user && implicit_sup && pg_user);             // R5
      w = r && (pg_rw || (!mode_user && !ctl_wp));              // R3
      x = !pg_nx && (mode_user || !(ctl_smep && pg_user));      // R4
      if (!ctl_lma)     kreg = 32'h0;                           // R6
      else if (pg_user) kreg = ctl_pke ? usr_key_rights : 32'h0;
      else              kreg = ctl_pks ? sup_key_rights : 32'h0;
      ad = kreg[2*leaf_key];                                    // R7
      wd = kreg[2*leaf_key+1];
      kr = !ad;                                                 // R8
      kw = !ad && !(wd && (mode_user || ctl_wp));               // R9
      r = r && kr;
      w = w && kw;
      case (acc_type)
         2'd0:    begin need = kr;   have = r; end
         2'd1:    begin need = kw;   have = w; end
         default: begin need = 1'b1; have = x; end
      endcase
      return {!need, !have, x, w, r};                           // R10 R11
   endfunction

   task automatic check_out(input string tag, input logic v, input logic [4:0] exp);
      n_cmp++;
      if (out_valid !== v || {pk_err, fault, rights} !== exp) begin
         n_bad++;
         $display("FAIL %s: actual v=%b pk=%b f=%b rights=%b expected v=%b pk=%b f=%b rights=%b",
                  tag, out_valid, pk_err, fault, rights, v, exp[4], exp[3], exp[2:0]);
      end
   endtask

   task automatic set_idle();
      in_valid = 0; pg_user = 0; pg_rw = 0; pg_nx = 0; leaf_key = 0; acc_type = 0;
      mode_user = 0; implicit_sup = 0; ctl_lma = 0; ctl_wp = 0; ctl_smep = 0;
      ctl_pke = 0; ctl_pks = 0; usr_key_rights = 0; sup_key_rights = 0;
   endtask

   // Drive current inputs for one beat, sample at the following falling edge
   task automatic beat(input string tag);
      logic [4:0] exp;
      exp = model();
      in_valid = 1'b1;
      @(negedge clk);
      check_out(tag, 1'b1, exp);
   endtask

   task automatic t_reset();
      set_idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_out("R1 reset", 1'b0, 5'b00000);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 idle after reset", 1'b0, 5'b00000);
   endtask

   task automatic t_hold();
      logic [4:0] kept;
      set_idle();
      ctl_lma = 1; pg_user = 1; pg_rw = 1; mode_user = 1; acc_type = 1;
      beat("R1 write beat");
      kept = {pk_err, fault, rights};
      in_valid = 1'b0;
      pg_user = 0; acc_type = 2;           // would fault if captured
      @(negedge clk);
      check_out("R1 no beat holds outputs", 1'b0, kept);
   endtask

   task automatic t_user_viol();
      set_idle();
      ctl_lma = 1; ctl_pke = 1; ctl_pks = 1;
      usr_key_rights = 32'hFFFF_FFFF; sup_key_rights = 32'hFFFF_FFFF;
      mode_user = 1; pg_user = 0; pg_rw = 1; leaf_key = 4'd5; acc_type = 0;
      beat("R2 user on supervisor page, key AD");
      check_out("R2 rights cleared, no pk", 1'b1, 5'b01000);
   endtask

   task automatic t_overlap();
      set_idle();
      ctl_lma = 1; ctl_pke = 1; pg_user = 1; pg_rw = 0; mode_user = 1;
      leaf_key = 4'd9; usr_key_rights = 32'h1 << 18; acc_type = 1;
      beat("R11 page and key both deny write");
      check_out("R11 fault with pk", 1'b1, 5'b11100);
   endtask

   task automatic t_ad_exec();
      set_idle();
      ctl_lma = 1; ctl_pks = 1; pg_user = 0; pg_rw = 1;
      leaf_key = 4'd15; sup_key_rights = 32'h4000_0000; acc_type = 2;
      beat("R8 AD leaves fetch allowed");
      check_out("R8 exec kept", 1'b1, 5'b00100);
      acc_type = 3;
      beat("R10 code 3 behaves as fetch");
      check_out("R10 code 3 fetch", 1'b1, 5'b00100);
      acc_type = 0;
      beat("R8 AD denies read");
      check_out("R8 read denied with pk", 1'b1, 5'b11100);
   endtask

   task automatic t_wd_wp();
      set_idle();
      ctl_lma = 1; ctl_pks = 1; pg_user = 0; pg_rw = 1; acc_type = 1;
      leaf_key = 4'd3; sup_key_rights = 32'h2 << 6;
      beat("R9 WD ignored for supervisor with WP clear");
      check_out("R9 write allowed", 1'b1, 5'b00111);
      ctl_wp = 1;
      beat("R9 WD applies with WP set");
      check_out("R9 write denied with pk", 1'b1, 5'b11101);
   endtask

   task automatic t_sweep();
      for (int k = 0; k < 16; k++)
         for (int c = 0; c < 32; c++)
            for (int m = 0; m < 3; m++)
               for (int p = 0; p < 8; p++)
                  for (int kr = 0; kr < 4; kr++)
                     for (int a = 0; a < 3; a++) begin
                        leaf_key = 4'(k);
                        {ctl_lma, ctl_wp, ctl_smep, ctl_pke, ctl_pks} = 5'(c);
                        mode_user = (m == 1);
                        implicit_sup = (m == 2);
                        {pg_user, pg_rw, pg_nx} = 3'(p);
                        usr_key_rights = 32'hFFFF_FFFF;
                        usr_key_rights[2*k +: 2] = 2'(kr);
                        sup_key_rights = 32'hFFFF_FFFF;
                        sup_key_rights[2*k +: 2] = {kr[0], kr[1]};
                        acc_type = 2'(a);
                        beat("R3 R4 R5 R6 R7 R8 R9 R10 R11 sweep");
                     end
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R1: actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      set_idle();
      rst_n = 1'b0;
      @(negedge clk);
      t_reset();
      t_hold();
      t_user_viol();
      t_overlap();
      t_ad_exec();
      t_wd_wp();
      t_sweep();
      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule